// File: doc/BRIEF.md
# Slot-Timing Native Clock with Trigger Realignment

This block keeps slot time for a frequency-hopping radio baseband. A phase counter counts system clock cycles inside each half-slot. When it reaches a programmable limit it wraps, and a 28-bit native clock counter steps once. Firmware reaches every register through a small synchronous register bus. The bus has a single address, a write strobe, write data and registered read data.

A correlator pulse tells a slave that the master's access code has just been seen. On that pulse the block does two things in the same cycle. It stores the phase that was live at that moment, and it reloads the phase counter with a corrected value that firmware prepared beforehand. This realigns the slave's half-slot boundary to the master. Firmware can then compare the stored phase with the corrected one to estimate drift between the two clocks.

A further 28-bit register holds a clock value that firmware loads. This can be selected native-clock fields or the master's clock as estimated in local time. Hop selection, drift arithmetic and the correlator itself sit outside the block.

Top module: `slot_clock`

## Requirements
- R1: After reset the native clock, the phase, the read data and all registers are zero.
- R2: While the phase is below the limit and no trigger or phase write occurs, the phase rises by one per cycle. When the phase is at or above the limit, it becomes zero on the next cycle.
- R3: The native clock rises by one, modulo 2^28, in the cycle after the phase is at or above the limit. It holds its value in every other cycle unless firmware writes it.
- R4: With a limit of zero the phase stays at zero and the native clock rises every cycle.
- R5: A trigger cycle copies the phase present in that cycle into the capture register, which reads at address 4. Bus writes to address 4 are ignored.
- R6: In the cycle after a trigger the phase equals the correction register (address 2) as it stood in the trigger cycle. This holds even if firmware writes the phase in the same cycle.
- R7: A bus write to address 0 (native clock, data bits 27:0) or address 1 (phase, data bits 14:0) shows on the output in the next cycle. A clock write overrides that cycle's increment.
- R8: Address 5 stores a 28-bit estimated clock from data bits 27:0. Reads of it return zero in bits 31:28.
- R9: Read data is registered. After an edge, bus_rdata holds the register selected by bus_addr before that edge. The map is 0 clock, 1 phase, 2 correction, 3 limit, 4 capture, 5 estimate, and 6 and 7 read as zero. Unused upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| corr_trig | input | 1 | Single-cycle correlator pulse |
| native_clk | output | 28 | Native clock count |
| phase | output | 15 | Phase within the half-slot, in system cycles |

## Verification
The bench first targets the trigger cycle. A trigger that coincides with a phase write must reload the correction value. A design that let the write win would leave the slave misaligned. The capture must hold the pre-trigger phase and not the reloaded one, or the drift estimate would read as zero. A second group of cases covers the wrap. Limit zero must step the clock every cycle. A phase written above the limit must wrap at once and not count through the full 15-bit range. A clock at 2^28-1 must roll to zero. Random traffic then mixes short limits with triggers, writes and reads.

// File: rtl/slot_clock_pkg.sv
package slot_clock_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CLOCK = 3'd0,
    RA_PHASE = 3'd1,
    RA_CORR  = 3'd2,
    RA_LIMIT = 3'd3,
    RA_CAPT  = 3'd4,
    RA_EST   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/sc_phase.sv
module sc_phase #(
  parameter int PH_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trig,
  input  logic            ld_en,
  input  logic [PH_W-1:0] ld_val,
  input  logic [PH_W-1:0] corr,
  input  logic [PH_W-1:0] limit,
  output logic [PH_W-1:0] phase_q,
  output logic            wrap
);
  // wrap also fires when a load put the phase beyond the limit
  assign wrap = (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst)
      phase_q <= '0;
    else if (trig)
      phase_q <= corr;
    else if (ld_en)
      phase_q <= ld_val;
    else if (wrap)
      phase_q <= '0;
    else
      phase_q <= phase_q + PH_W'(1);
  end
endmodule

// File: rtl/sc_count.sv
module sc_count #(
  parameter int CLK_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ld_en,
  input  logic [CLK_W-1:0] ld_val,
  output logic [CLK_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (ld_en)
      cnt_q <= ld_val;
    else if (step)
      cnt_q <= cnt_q + CLK_W'(1);
  end
endmodule

// File: rtl/sc_regs.sv
module sc_regs
  import slot_clock_pkg::*;
#(
  parameter int PH_W   = 15,
  parameter int CLK_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              trig,
  input  logic [PH_W-1:0]   phase_q,
  input  logic [CLK_W-1:0]  cnt_q,
  output logic              wr_clock,
  output logic              wr_phase,
  output logic [PH_W-1:0]   corr_q,
  output logic [PH_W-1:0]   lim_q,
  output logic [PH_W-1:0]   cap_q,
  output logic [CLK_W-1:0]  est_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_mux;

  assign wr_clock = wr && (addr == RA_CLOCK);
  assign wr_phase = wr && (addr == RA_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_q <= '0;
      lim_q  <= '0;
      est_q  <= '0;
    end else if (wr) begin
      case (addr)
        RA_CORR:  corr_q <= wdata[PH_W-1:0];
        RA_LIMIT: lim_q  <= wdata[PH_W-1:0];
        RA_EST:   est_q  <= wdata[CLK_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cap_q <= '0;
    else if (trig)
      cap_q <= phase_q;
  end

  always_comb begin
    case (addr)
      RA_CLOCK: rd_mux = DATA_W'(cnt_q);
      RA_PHASE: rd_mux = DATA_W'(phase_q);
      RA_CORR:  rd_mux = DATA_W'(corr_q);
      RA_LIMIT: rd_mux = DATA_W'(lim_q);
      RA_CAPT:  rd_mux = DATA_W'(cap_q);
      RA_EST:   rd_mux = DATA_W'(est_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else
      rdata_q <= rd_mux;
  end
endmodule

// File: rtl/slot_clock.sv
module slot_clock
  import slot_clock_pkg::*;
#(
  parameter int PH_W   = 15,
  parameter int CLK_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              corr_trig,
  output logic [CLK_W-1:0]  native_clk,
  output logic [PH_W-1:0]   phase
);
  logic             wr_clock, wr_phase, wrap;
  logic [PH_W-1:0]  corr_q, lim_q, cap_q, phase_q;
  logic [CLK_W-1:0] est_q, cnt_q;

  sc_regs #(.PH_W(PH_W), .CLK_W(CLK_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .trig(corr_trig), .phase_q(phase_q), .cnt_q(cnt_q),
    .wr_clock(wr_clock), .wr_phase(wr_phase), .corr_q(corr_q),
    .lim_q(lim_q), .cap_q(cap_q), .est_q(est_q), .rdata_q(bus_rdata)
  );

  sc_phase #(.PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .trig(corr_trig), .ld_en(wr_phase),
    .ld_val(bus_wdata[PH_W-1:0]), .corr(corr_q), .limit(lim_q),
    .phase_q(phase_q), .wrap(wrap)
  );

  sc_count #(.CLK_W(CLK_W)) u_count (
    .clk(clk), .rst(rst), .step(wrap), .ld_en(wr_clock),
    .ld_val(bus_wdata[CLK_W-1:0]), .cnt_q(cnt_q)
  );

  assign native_clk = cnt_q;
  assign phase      = phase_q;
endmodule

// File: rtl/slot_clock_chk.sv
module slot_clock_chk #(
  parameter int PH_W  = 15,
  parameter int CLK_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       bus_addr,
  input logic             bus_wr,
  input logic             corr_trig,
  input logic [PH_W-1:0]  phase,
  input logic [CLK_W-1:0] native_clk,
  input logic [PH_W-1:0]  lim_q,
  input logic [PH_W-1:0]  corr_q,
  input logic [PH_W-1:0]  cap_q
);
  logic ph_wr, ck_wr;
  assign ph_wr = bus_wr && (bus_addr == 3'd1);
  assign ck_wr = bus_wr && (bus_addr == 3'd0);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!corr_trig && !ph_wr && phase < lim_q) |=> phase == PH_W'($past(phase) + PH_W'(1)));
  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!corr_trig && !ph_wr && phase >= lim_q) |=> phase == '0);
  // R3
  clock_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ck_wr && phase >= lim_q) |=> native_clk == CLK_W'($past(native_clk) + CLK_W'(1)));
  // R3
  clock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ck_wr && phase < lim_q) |=> $stable(native_clk));
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    corr_trig |=> cap_q == $past(phase));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    corr_trig |=> phase == $past(corr_q));
endmodule

bind slot_clock slot_clock_chk #(.PH_W(PH_W), .CLK_W(CLK_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .corr_trig(corr_trig), .phase(phase), .native_clk(native_clk),
  .lim_q(lim_q), .corr_q(corr_q), .cap_q(cap_q)
);

// File: tb/tb_slot_clock.sv
`timescale 1ns/1ps
module tb_slot_clock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        corr_trig = 1'b0;
  logic [27:0] native_clk;
  logic [14:0] phase;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [27:0] m_clk, m_est;
  logic [14:0] m_ph, m_corr, m_lim, m_cap;
  logic [31:0] m_rd;

  always #2.5 clk = ~clk;

  slot_clock dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .corr_trig(corr_trig),
    .native_clk(native_clk), .phase(phase)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {4'd0, m_clk};
      3'd1: return {17'd0, m_ph};
      3'd2: return {17'd0, m_corr};
      3'd3: return {17'd0, m_lim};
      3'd4: return {17'd0, m_cap};
      3'd5: return {4'd0, m_est};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, model the edge, compare after it
  task automatic step(input string tag, input logic wr, input logic [2:0] a,
                      input logic [31:0] wd, input logic trg);
    logic        wrap;
    logic [27:0] n_clk, n_est;
    logic [14:0] n_ph, n_corr, n_lim, n_cap;
    bus_wr = wr; bus_addr = a; bus_wdata = wd; corr_trig = trg;
    wrap   = (m_ph >= m_lim);
    m_rd   = model_read(a);
    n_ph   = trg ? m_corr : (wr && a == 3'd1) ? wd[14:0] : wrap ? 15'd0 : m_ph + 15'd1;
    n_clk  = (wr && a == 3'd0) ? wd[27:0] : wrap ? m_clk + 28'd1 : m_clk;
    n_cap  = trg ? m_ph : m_cap;
    n_corr = (wr && a == 3'd2) ? wd[14:0] : m_corr;
    n_lim  = (wr && a == 3'd3) ? wd[14:0] : m_lim;
    n_est  = (wr && a == 3'd5) ? wd[27:0] : m_est;
    @(posedge clk); #1;
    m_ph = n_ph; m_clk = n_clk; m_cap = n_cap;
    m_corr = n_corr; m_lim = n_lim; m_est = n_est;
    check(tag, "phase", {17'd0, phase}, {17'd0, m_ph});
    check(tag, "native_clk", {4'd0, native_clk}, {4'd0, m_clk});
    check(tag, "rdata", bus_rdata, m_rd);
    @(negedge clk);
    bus_wr = 1'b0; corr_trig = 1'b0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 3'd6, 32'd0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    m_clk = '0; m_est = '0; m_ph = '0; m_corr = '0; m_lim = '0; m_cap = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", "phase", {17'd0, phase}, 32'd0);
    check("R1", "native_clk", {4'd0, native_clk}, 32'd0);
    check("R1", "rdata", bus_rdata, 32'd0);
    for (int a = 0; a < 6; a++) step("R1", 1'b0, 3'(a), 32'd0, 1'b0);

    // R2 count and wrap with limit 5
    step("R2", 1'b1, 3'd3, 32'd5, 1'b0);
    idle("R2", 14);
    // R2 phase written above the limit wraps at once
    step("R2", 1'b1, 3'd1, 32'd40, 1'b0);
    idle("R2", 3);

    // R3 clock rolls over from all ones
    step("R3", 1'b1, 3'd3, 32'd2, 1'b0);
    step("R3", 1'b1, 3'd0, 32'h0FFF_FFFF, 1'b0);
    idle("R3", 6);

    // R4 limit zero
    step("R4", 1'b1, 3'd3, 32'd0, 1'b0);
    idle("R4", 5);

    // R6 trigger reload, then R5 capture readback
    step("R6", 1'b1, 3'd3, 32'd200, 1'b0);
    step("R6", 1'b1, 3'd2, 32'd100, 1'b0);
    idle("R6", 4);
    step("R6", 1'b0, 3'd4, 32'd0, 1'b1);
    step("R5", 1'b0, 3'd4, 32'd0, 1'b0);
    check("R5", "capture read", bus_rdata, {17'd0, m_cap});
    // R6 trigger beats same-cycle phase write
    step("R6", 1'b1, 3'd1, 32'd7, 1'b1);
    check("R6", "priority", {17'd0, phase}, 32'd100);
    // R5 write to capture ignored
    step("R5", 1'b1, 3'd4, 32'h1234, 1'b0);
    step("R5", 1'b0, 3'd4, 32'd0, 1'b0);

    // R7 writes land next cycle
    step("R7", 1'b1, 3'd0, 32'hF00_0ABC, 1'b0);
    step("R7", 1'b1, 3'd1, 32'd150, 1'b0);
    idle("R7", 2);

    // R8 estimate register, upper bits zero
    step("R8", 1'b1, 3'd5, 32'hFFFF_FFFF, 1'b0);
    step("R8", 1'b0, 3'd5, 32'd0, 1'b0);
    check("R8", "estimate", bus_rdata, 32'h0FFF_FFFF);

    // R9 map and unused addresses
    for (int a = 0; a < 8; a++) step("R9", 1'b0, 3'(a), 32'd0, 1'b0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      logic [2:0]  a;
      logic [31:0] wd;
      r  = $urandom_range(0, 99);
      a  = 3'($urandom_range(0, 7));
      wd = $urandom();
      if (a == 3'd3) wd = 32'($urandom_range(0, 12));
      if (a == 3'd1 || a == 3'd2) wd = 32'($urandom_range(0, 20));
      if (a == 3'd0 && r < 5) wd = 32'h0FFF_FFFE;
      step("R2/R3/R5/R6/R7", r < 25, a, wd, $urandom_range(0, 9) == 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule